// File: doc/BRIEF.md
# Register Lock and Claim Tag Unit

This unit sits beside the register file of a debug component and controls which writes are allowed to reach it. It watches every write on the register bus and keeps a lock state. While the lock is engaged, only writes to the key register get through. Every other write is held back, and the unit stays silent on the write-qualifier output that the rest of the register file uses. Reads are never blocked. A status register reports that a lock exists, whether it is engaged now, and the width of the key register.

Software releases the lock by writing one 32-bit key value to the key register. Any other value written there engages the lock again.

The unit also holds a small claim tag. Debuggers and application software use it to agree on who owns the component, and it has no effect on anything else. Two registers give access to the tag:
- The set register is write-1-to-set. Reading it returns the mask of implemented claim bits.
- The clear register is write-1-to-clear. Reading it returns the current tag.

Writes to these two registers are control writes, so the lock blocks them as well. For its own four addresses, the unit drives read data combinationally and flags a read hit.

Top module: `reg_lock_claim`

## Requirements
- R1: After reset the lock is engaged (status bit 1 reads 1) and every claim bit is 0.
- R2: A granted write of 0xC5ACCE55 to the key register disengages the lock from the next cycle.
- R3: A write of any other value to the key register engages the lock from the next cycle, whether or not it was engaged before.
- R4: While the lock is engaged, `wrGrant` stays low for a write to any address except the key register, and such writes leave the claim tag unchanged. A write to the key register is always granted.
- R5: While the lock is disengaged, `wrGrant` equals `wrEn` for every address. A cycle with `wrEn` low changes no state.
- R6: A read of the status register returns bit 0 = 1 (lock present), bit 1 = lock engaged, bit 2 = 0 (32-bit key register), and zeros above.
- R7: A read of the claim-set register returns the implemented mask, 0xF in bits 3:0, with zeros above.
- R8: A granted write to the claim-set register sets each claim bit whose data bit is 1. Bits written with 0 keep their value.
- R9: A granted write to the claim-clear register clears each claim bit whose data bit is 1 and keeps the others. A read of the claim-clear register returns the tag in bits 3:0.
- R10: `rdHit` is 1 exactly when `addr` selects one of the four unit registers. `rdData` is 0 for the key register and for every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register bus write strobe |
| addr | input | 10 | Word address of the current access |
| wrData | input | 32 | Write data |
| wrGrant | output | 1 | Write qualifier for the whole register file |
| rdHit | output | 1 | Address selects a register of this unit |
| rdData | output | 32 | Read data for this unit's registers |

## Verification
The hardest situations to reach are a claim write that arrives while the lock is engaged and a key write that misses the key value by a single bit. Both must leave the state visibly untouched, and that can only be seen through later reads.

The stimulus first drives directed sequences: blocked claim writes before and after unlocking, relocking with near-miss keys, and set/clear masks containing zeros. It then runs a long pseudo-random stream. That stream weights addresses toward the four unit registers and chooses key data from the true key, single-bit neighbours of it, and arbitrary values. Between writes, reads of status and claim-clear expose the lock and tag against a behavioural model.

// File: rtl/reg_lock_claim_pkg.sv
package reg_lock_claim_pkg;

  // strobes from the decode/control half to the storage half
  typedef struct packed {
    logic keyWr;
    logic setWr;
    logic clrWr;
  } lockStrobeT;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_STAT = 3'd1,
    RD_SET  = 3'd2,
    RD_CLR  = 3'd3,
    RD_KEY  = 3'd4
  } rdSelT;

endpackage

// File: rtl/reg_lock_claim_ctrl.sv
module reg_lock_claim_ctrl
  import reg_lock_claim_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 10'h3F0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 10'h3F1,
  parameter logic [ADDR_W-1:0] SET_ADDR  = 10'h3E0,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 10'h3E1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              locked,
  output lockStrobeT        strb,
  output logic              wrGrant,
  output logic              rdHit,
  output rdSelT             rdSel
);

  localparam int N_REGS = 4;

  logic [N_REGS-1:0] hitVec;
  logic isKey;

  always_comb begin
    hitVec[0] = (addr == KEY_ADDR);
    hitVec[1] = (addr == STAT_ADDR);
    hitVec[2] = (addr == SET_ADDR);
    hitVec[3] = (addr == CLR_ADDR);
  end

  assign isKey   = hitVec[0];
  assign wrGrant = wrEn && (!locked || isKey);
  assign rdHit   = |hitVec;

  always_comb begin
    strb.keyWr = wrEn && hitVec[0];
    strb.setWr = wrGrant && hitVec[2];
    strb.clrWr = wrGrant && hitVec[3];
  end

  always_comb begin
    unique case (1'b1)
      hitVec[0]: rdSel = RD_KEY;
      hitVec[1]: rdSel = RD_STAT;
      hitVec[2]: rdSel = RD_SET;
      hitVec[3]: rdSel = RD_CLR;
      default:   rdSel = RD_NONE;
    endcase
  end

  // R10
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R4
  locked_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !isKey) |-> !(strb.setWr || strb.clrWr || wrGrant));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(wrGrant || strb.keyWr || strb.setWr || strb.clrWr));

endmodule

// File: rtl/reg_lock_claim_dp.sv
module reg_lock_claim_dp
  import reg_lock_claim_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CLAIM_W = 4,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55
) (
  input  logic              clk,
  input  logic              rstN,
  input  lockStrobeT        strb,
  input  rdSelT             rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic              locked,
  output logic [DATA_W-1:0] rdData
);

  localparam int STAT_PAD  = DATA_W - 3;
  localparam int CLAIM_PAD = DATA_W - CLAIM_W;

  logic [CLAIM_W-1:0] claimTag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          locked <= 1'b1;
    else if (strb.keyWr) locked <= (wrData != UNLOCK_KEY);
  end

  for (genvar i = 0; i < CLAIM_W; i++) begin : g_claim
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          claimTag[i] <= 1'b0;
      else if (strb.setWr && wrData[i])   claimTag[i] <= 1'b1;
      else if (strb.clrWr && wrData[i])   claimTag[i] <= 1'b0;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_STAT: rdData = {{STAT_PAD{1'b0}}, 1'b0, locked, 1'b1};
      RD_SET:  rdData = {{CLAIM_PAD{1'b0}}, {CLAIM_W{1'b1}}};
      RD_CLR:  rdData = {{CLAIM_PAD{1'b0}}, claimTag};
      default: rdData = '0;
    endcase
  end

  // R2
  unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.keyWr && wrData == UNLOCK_KEY) |=> !locked);

  // R3
  relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.keyWr && wrData != UNLOCK_KEY) |=> locked);

  // R4
  claim_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(claimTag));

  // R8
  claim_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWr |=> ((claimTag & $past(wrData[CLAIM_W-1:0])) == $past(wrData[CLAIM_W-1:0])));

  // R9
  claim_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrWr |=> ((claimTag & $past(wrData[CLAIM_W-1:0])) == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.keyWr || strb.setWr || strb.clrWr) |=> ($stable(claimTag) && $stable(locked)));

endmodule

// File: rtl/reg_lock_claim.sv
module reg_lock_claim
  import reg_lock_claim_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int CLAIM_W = 4,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 10'h3F0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 10'h3F1,
  parameter logic [ADDR_W-1:0] SET_ADDR  = 10'h3E0,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 10'h3E1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrGrant,
  output logic              rdHit,
  output logic [DATA_W-1:0] rdData
);

  lockStrobeT strb;
  rdSelT      rdSel;
  logic       locked;

  reg_lock_claim_ctrl #(
    .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR),
    .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .locked(locked),
    .strb(strb), .wrGrant(wrGrant), .rdHit(rdHit), .rdSel(rdSel)
  );

  reg_lock_claim_dp #(
    .DATA_W(DATA_W), .CLAIM_W(CLAIM_W), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .wrData(wrData),
    .locked(locked), .rdData(rdData)
  );

endmodule

// File: tb/reg_lock_claim_tb.sv
module reg_lock_claim_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [9:0]  KEY_A  = 10'h3F0;
  localparam logic [9:0]  STAT_A = 10'h3F1;
  localparam logic [9:0]  SET_A  = 10'h3E0;
  localparam logic [9:0]  CLR_A  = 10'h3E1;
  localparam logic [31:0] KEY    = 32'hC5AC_CE55;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        wrGrant, rdHit;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit mLocked = 1'b1;
  logic [3:0] mTag = 4'h0;
  int unsigned lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_lock_claim u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .wrGrant(wrGrant), .rdHit(rdHit), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at negedge, compare before posedge, advance model at posedge
  task automatic step(input bit we, input logic [9:0] a, input logic [31:0] d,
                      input string rdReq = "");
    bit expGrant, expHit;
    logic [31:0] expRd;
    string gReq, rReq;
    @(negedge clk);
    wrEn = we; addr = a; wrData = d;
    #2;
    expGrant = we && (!mLocked || a == KEY_A);
    expHit   = (a == KEY_A) || (a == STAT_A) || (a == SET_A) || (a == CLR_A);
    if (a == STAT_A)     begin expRd = {29'b0, 1'b0, mLocked, 1'b1}; rReq = "R6"; end
    else if (a == SET_A) begin expRd = 32'h0000_000F;                rReq = "R7"; end
    else if (a == CLR_A) begin expRd = {28'b0, mTag};                rReq = "R9"; end
    else                 begin expRd = 32'h0;                         rReq = "R10"; end
    if (rdReq != "") rReq = rdReq;
    if (!we) gReq = "R5";
    else if (a == KEY_A || mLocked) gReq = "R4";
    else gReq = "R5";
    check(gReq, {31'b0, wrGrant}, {31'b0, expGrant});
    check("R10", {31'b0, rdHit}, {31'b0, expHit});
    check(rReq, rdData, expRd);
    @(posedge clk);
    if (expGrant) begin
      if (a == KEY_A)      mLocked = (d != KEY);
      else if (a == SET_A) mTag = mTag | d[3:0];
      else if (a == CLR_A) mTag = mTag & ~d[3:0];
    end
  endtask

  function automatic int unsigned nextRand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: reset state
    step(0, STAT_A, 0, "R1");
    step(0, CLR_A, 0, "R1");
    // R4: claim writes blocked while locked
    step(1, SET_A, 32'hF, "R4");
    step(0, CLR_A, 0, "R4");
    step(1, 10'h010, 32'hFFFF_FFFF);
    // R3: near-miss key keeps lock
    step(1, KEY_A, KEY ^ 32'h1);
    step(0, STAT_A, 0, "R3");
    // R2: unlock
    step(1, KEY_A, KEY);
    step(0, STAT_A, 0, "R2");
    step(0, KEY_A, 0, "R10");
    // R8: set with zeros untouched
    step(1, SET_A, 32'h5);
    step(0, CLR_A, 0, "R8");
    step(1, SET_A, 32'hFFFF_FFF2);
    step(0, CLR_A, 0, "R8");
    // R9: clear subset
    step(1, CLR_A, 32'h9);
    step(0, CLR_A, 0, "R9");
    step(0, SET_A, 0, "R7");
    // R5: unlocked writes to foreign address granted
    step(1, 10'h123, 32'hDEAD_BEEF);
    step(0, 10'h123, 0, "R10");
    // R3: relock with zero, claim frozen again
    step(1, KEY_A, 32'h0);
    step(0, STAT_A, 0, "R3");
    step(1, CLR_A, 32'hF, "R4");
    step(0, CLR_A, 0, "R4");
    // pseudo-random stream
    for (int i = 0; i < 600; i++) begin
      int unsigned r, s;
      logic [9:0]  a;
      logic [31:0] d;
      r = nextRand();
      s = (r >> 8) % 7;
      case (s)
        0: a = KEY_A;
        1: a = STAT_A;
        2: a = SET_A;
        3, 4: a = CLR_A;
        default: a = 10'(nextRand());
      endcase
      case ((r >> 16) % 4)
        0: d = KEY;
        1: d = KEY ^ (32'h1 << ((r >> 20) % 32));
        default: d = nextRand();
      endcase
      step(((r >> 4) % 3) != 0, a, d);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule